// File: doc/BRIEF.md
# SD Card Clock Generator with Identification/Data Divisor Modes

This block derives the SD card clock from the core clock. Software programs an 11-bit divisor value. The value is stored as the division ratio minus two, so the SD clock runs at the core frequency divided by (value + 2). With a 250 MHz core clock, the values 0 through 7 give 125, 83.3, 62.5, 50, 41.7, 35.7, 31.3 and 27.8 MHz. The largest value, 0x7FF, divides by 2049.

Two divisor modes exist. During card identification the whole 11-bit value sets the ratio. Once the data sequencer raises its mode input, only the three least significant bits of the value count. A slow-card bit in the host configuration word overrides this and keeps the full value in force in both modes.

The output duty cycle is 50% for every ratio. Odd ratios use a half-cycle phase taken on the falling core edge. A changed ratio is adopted only where one SD clock period ends and the next begins. The block also produces a one-core-cycle enable strobe in the last core cycle of each SD period, which marks the coming SD rising edge.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the divisor value is 507 and the slow-card bit is clear. The SD clock is low while reset is held, and the first full period after reset lasts 509 core cycles.
- R2: When `data_mode_i` is low, the ratio is the full 11-bit divisor value plus two.
- R3: When `data_mode_i` is high and the slow-card bit is clear, the ratio is bits [2:0] of the divisor value plus two. Bits [10:3] have no effect.
- R4: The slow-card bit is bit 3 of a write to address 1. When it is set, the ratio is the full value plus two in both modes.
- R5: For an even ratio N, the SD clock is high for N/2 core cycles of each N-cycle period.
- R6: For an odd ratio N, the SD clock is high for exactly N/2 core cycles, a half-cycle resolution, within each N-cycle period.
- R7: A change to the divisor, the slow-card bit or the mode takes effect only at the next SD period boundary. The period in progress keeps its length.
- R8: `sd_clk_en_o` is high for exactly one core cycle per SD period. That cycle is the last core cycle of the period, and the SD clock is low during it.
- R9: Address 0 of the write port holds the divisor value and address 1 holds the configuration word. Only bit 3 of the configuration word is stored. A write while `cfg_we_i` is low is ignored.
- R10: The maximum value 0x7FF gives a ratio of 2049 with a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 1 | Register select: 0 divisor value, 1 configuration word |
| cfg_wdata_i | input | 11 | Write data |
| data_mode_i | input | 1 | High while the data sequencer is in data transfer mode |
| sd_clk_o | output | 1 | SD card clock |
| sd_clk_en_o | output | 1 | Strobe in the last core cycle of each SD period |

## Verification
A register write lands at the next core rising edge. The new ratio is then adopted at the edge that follows the next strobe. The stimulus therefore waits out two strobes before it measures anything, so the old period has run out and the first new period is complete.

Period length is counted in core cycles between strobes, sampled on falling core edges, well away from the edge that updates the counter. The high time and the period of the SD clock are taken from the output's own edges in time units, which is how the half-cycle phase of odd ratios becomes visible. For the boundary test, the write is placed ten cycles into a long period, and the bench expects that period unchanged and the next one shortened.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int unsigned DIV_W_DEF     = 11;
    localparam int unsigned DATA_BITS_DEF = 3;
    localparam int unsigned RESET_DIV_DEF = 507;
    localparam int unsigned SLOW_BIT_DEF  = 3;

    typedef enum logic {
        ADDR_DIVISOR = 1'b0,
        ADDR_HOSTCFG = 1'b1
    } cfg_addr_e;
endpackage

// File: rtl/sdclk_cfg_regs.sv
module sdclk_cfg_regs #(
    parameter int unsigned DIV_W     = sdclk_pkg::DIV_W_DEF,
    parameter int unsigned RESET_DIV = sdclk_pkg::RESET_DIV_DEF,
    parameter int unsigned SLOW_BIT  = sdclk_pkg::SLOW_BIT_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             addr_i,
    input  logic [DIV_W-1:0] wdata_i,
    output logic [DIV_W-1:0] div_o,
    output logic             slow_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             slow;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            if (addr_i == sdclk_pkg::ADDR_DIVISOR) begin
                regs_d.div = wdata_i;
            end else begin
                regs_d.slow = wdata_i[SLOW_BIT];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.div  <= DIV_W'(RESET_DIV);
            regs_q.slow <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign div_o  = regs_q.div;
    assign slow_o = regs_q.slow;
endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel #(
    parameter int unsigned DIV_W     = sdclk_pkg::DIV_W_DEF,
    parameter int unsigned DATA_BITS = sdclk_pkg::DATA_BITS_DEF,
    localparam int unsigned RATIO_W  = DIV_W + 1
) (
    input  logic [DIV_W-1:0]   div_i,
    input  logic               slow_i,
    input  logic               data_mode_i,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [DIV_W-1:0] data_div;
    logic [DIV_W-1:0] eff_div;

    generate
        if (DATA_BITS < DIV_W) begin : g_trunc
            assign data_div = {{(DIV_W-DATA_BITS){1'b0}}, div_i[DATA_BITS-1:0]};
        end else begin : g_full
            assign data_div = div_i;
        end
    endgenerate

    always_comb begin
        eff_div = (data_mode_i && !slow_i) ? data_div : div_i;
        ratio_o = {1'b0, eff_div} + RATIO_W'(2);
    end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
    parameter int unsigned RATIO_W     = sdclk_pkg::DIV_W_DEF + 1,
    parameter int unsigned RESET_RATIO = sdclk_pkg::RESET_DIV_DEF + 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_nxt_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               sd_clk_o,
    output logic               sd_clk_en_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               hi;
    } phase_t;

    phase_t st_d, st_q;
    logic   wrap;
    logic   lo_q;
    logic [RATIO_W:0] half;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == st_q.ratio - RATIO_W'(1));
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_nxt_i;
        end else begin
            st_d.cnt = st_q.cnt + RATIO_W'(1);
        end
        half    = ({1'b0, st_d.ratio} + (RATIO_W+1)'(1)) >> 1;
        st_d.hi = ({1'b0, st_d.cnt} < half);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= RATIO_W'(RESET_RATIO - 1);
            st_q.ratio <= RATIO_W'(RESET_RATIO);
            st_q.hi    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-cycle delayed copy used to trim odd-ratio high phases.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q <= 1'b0;
        end else begin
            lo_q <= st_q.hi;
        end
    end

    assign sd_clk_o    = st_q.ratio[0] ? (st_q.hi & lo_q) : st_q.hi;
    assign sd_clk_en_o = wrap;
    assign ratio_o     = st_q.ratio;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int unsigned DIV_W     = sdclk_pkg::DIV_W_DEF,
    parameter int unsigned DATA_BITS = sdclk_pkg::DATA_BITS_DEF,
    parameter int unsigned RESET_DIV = sdclk_pkg::RESET_DIV_DEF,
    parameter int unsigned SLOW_BIT  = sdclk_pkg::SLOW_BIT_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic             cfg_addr_i,
    input  logic [DIV_W-1:0] cfg_wdata_i,
    input  logic             data_mode_i,
    output logic             sd_clk_o,
    output logic             sd_clk_en_o
);
    localparam int unsigned RATIO_W     = DIV_W + 1;
    localparam int unsigned RESET_RATIO = RESET_DIV + 2;

    logic [DIV_W-1:0]   div_q;
    logic               slow_card_q;
    logic [RATIO_W-1:0] ratio_nxt;
    logic [RATIO_W-1:0] ratio_q;

    sdclk_cfg_regs #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV),
        .SLOW_BIT  (SLOW_BIT)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .div_o   (div_q),
        .slow_o  (slow_card_q)
    );

    sdclk_ratio_sel #(
        .DIV_W     (DIV_W),
        .DATA_BITS (DATA_BITS)
    ) u_sel (
        .div_i       (div_q),
        .slow_i      (slow_card_q),
        .data_mode_i (data_mode_i),
        .ratio_o     (ratio_nxt)
    );

    sdclk_phase_gen #(
        .RATIO_W     (RATIO_W),
        .RESET_RATIO (RESET_RATIO)
    ) u_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ratio_nxt_i (ratio_nxt),
        .ratio_o     (ratio_q),
        .sd_clk_o    (sd_clk_o),
        .sd_clk_en_o (sd_clk_en_o)
    );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
    parameter int unsigned RATIO_W   = 12,
    parameter int unsigned DATA_BITS = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               data_mode_i,
    input logic               slow_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               sd_clk_o,
    input logic               sd_clk_en_o
);
    localparam int unsigned DATA_MAX_RATIO = (1 << DATA_BITS) + 1;

    // R1: the clock stays low while reset is held
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_reset_low_r1: assert (sd_clk_o !== 1'b1);
        end
    end

    // R3: data mode without the override selects a short ratio
    p_data_ratio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sd_clk_en_o && data_mode_i && !slow_i) |=> (ratio_i <= RATIO_W'(DATA_MAX_RATIO)));

    // R7: the active ratio moves only at a period boundary
    p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sd_clk_en_o |=> $stable(ratio_i));

    // R8: the strobe lasts a single core cycle
    p_single_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sd_clk_en_o |=> !sd_clk_en_o);

    // R8: the SD clock is low in the strobe cycle
    p_strobe_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sd_clk_en_o |-> !sd_clk_o);
endmodule

bind sdclk_gen sdclk_gen_chk #(
    .RATIO_W   (RATIO_W),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_mode_i (data_mode_i),
    .slow_i      (slow_card_q),
    .ratio_i     (ratio_q),
    .sd_clk_o    (sd_clk_o),
    .sd_clk_en_o (sd_clk_en_o)
);

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        we = 1'b0;
    logic        addr = 1'b0;
    logic [10:0] wdata = '0;
    logic        dmode = 1'b0;
    logic        sd_clk;
    logic        sd_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sdclk_gen i_sdclk_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .data_mode_i (dmode),
        .sd_clk_o    (sd_clk),
        .sd_clk_en_o (sd_en)
    );

    // {divisor, slow, data_mode, expected ratio}
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {11'd0,     1'b0, 1'b0, 12'd2},
        {11'd1,     1'b0, 1'b0, 12'd3},
        {11'd6,     1'b0, 1'b0, 12'd8},
        {11'd13,    1'b0, 1'b1, 12'd7},
        {11'd13,    1'b1, 1'b1, 12'd15},
        {11'h7FF,   1'b0, 1'b1, 12'd9},
        {11'd2,     1'b0, 1'b1, 12'd4},
        {11'h7FF,   1'b1, 1'b0, 12'd2049},
        {11'h7FF,   1'b0, 1'b0, 12'd2049}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [10:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!sd_en);
    endtask

    task automatic settle();
        wait_strobe();
        wait_strobe();
    endtask

    task automatic period_cycles(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sd_en);
    endtask

    task automatic duty(output int hi_ns, output int per_ns);
        realtime t1, t2, t3;
        @(posedge sd_clk); t1 = $realtime;
        @(negedge sd_clk); t2 = $realtime;
        @(posedge sd_clk); t3 = $realtime;
        hi_ns  = int'(t2 - t1);
        per_ns = int'(t3 - t1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, hi, per, exp;
        #1 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 clock low in reset", int'(sd_clk), 0);
        rst_n = 1'b1;
        wait_strobe();
        period_cycles(n);
        check("R1 reset ratio", n, 509);

        for (int i = 0; i < NV; i++) begin
            write_reg(1'b0, VEC[i][24:14]);
            write_reg(1'b1, {7'd0, VEC[i][13], 3'd0});
            dmode = VEC[i][12];
            exp = int'(VEC[i][11:0]);
            settle();
            period_cycles(n);
            check(dmode ? (VEC[i][13] ? "R4 slow override ratio" : "R3 data mode ratio")
                        : "R2 ident ratio", n, exp);
            duty(hi, per);
            check((exp % 2 == 0) ? "R5 even high time" : "R6 odd high time", hi, exp * 2);
            check(exp == 2049 ? "R10 max period" : "R8 period from edges", per, exp * 4);
        end

        // R7: write ten cycles into a 102-cycle period
        dmode = 1'b0;
        write_reg(1'b0, 11'd100);
        settle();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) begin
                we = 1'b1; addr = 1'b0; wdata = 11'd4;
            end else begin
                we = 1'b0;
            end
        end while (!sd_en);
        we = 1'b0;
        check("R7 current period kept", n, 102);
        period_cycles(n);
        check("R7 next period uses new value", n, 6);

        // R9: write with enable low is ignored
        @(negedge clk);
        addr = 1'b0; wdata = 11'd100; we = 1'b0;
        @(negedge clk);
        settle();
        period_cycles(n);
        check("R9 disabled write ignored", n, 6);

        // R9: only bit 3 of the configuration word is kept
        write_reg(1'b0, 11'd13);
        write_reg(1'b1, 11'h7F7);
        dmode = 1'b1;
        settle();
        period_cycles(n);
        check("R9 config bits other than 3 ignored", n, 7);
        write_reg(1'b1, 11'h008);
        settle();
        period_cycles(n);
        check("R9 config bit 3 stored", n, 15);

        // R8: strobe width one cycle
        wait_strobe();
        @(negedge clk);
        check("R8 strobe single cycle", int'(sd_en), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule